// File: doc/BRIEF.md
# Banked Register File with Result Forwarding

This block is the general-purpose register storage of a small 32-bit core. It holds sixteen 32-bit words in a primary bank and sixteen more in an alternate bank. A fast interrupt handler switches to the alternate bank and gets a full working set without saving anything. Two read ports are combinational. They serve the decode stage, which presents two source register numbers and reads both operands in the same cycle.

The write side has two paths. The first is an ordinary result writeback to any register. The second is a call-link strobe that puts the return address into the link register, index 15, when a subroutine call retires. A value being written in a cycle is forwarded straight to any read port that names the same register in the same bank. A dependent instruction therefore sees the fresh result without a stall. Register 0 holds the stack pointer only by software convention, and the hardware treats it like any other register.

Top module: `banked_regfile`

## Requirements
- R1: A cycle with `rst` high clears all registers in both banks to zero at the rising edge. When no write is active in the next cycle, every read returns zero.
- R2: When `wr_en` is high and `rst` is low, `wr_data` is stored into register `wr_addr` of bank `wr_bank` at the rising edge. Later reads return it until it is overwritten.
- R3: The two read ports are independent. `rd_data_a` shows register `rd_addr_a` and `rd_data_b` shows register `rd_addr_b`, both from bank `bank_sel` (0 = primary, 1 = alternate).
- R4: When `link_we` is high, `link_data` is stored into register 15 of bank `wr_bank`. If `wr_en` also targets register 15 in that cycle, `link_data` is the value stored and the value forwarded.
- R5: A call-link write and a normal write to a register other than 15 in the same cycle both take effect.
- R6: A read of the register being written in the current cycle returns the value being written in that cycle, provided the write bank equals `bank_sel`. This applies to both the normal and the link path.
- R7: When `wr_bank` differs from `bank_sel`, nothing is forwarded, and reads return the stored contents of the selected bank.
- R8: A write to one bank leaves the same register number in the other bank unchanged.
- R9: Register 0 is ordinary storage. It can be written, read and forwarded like any other register.
- R10: With `wr_en` and `link_we` both low, `wr_data`, `wr_addr` and `link_data` have no effect on storage or on read data.
- R11: Writes requested while `rst` is high are neither stored nor forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Bank used by both read ports |
| wr_en | input | 1 | Normal write strobe |
| wr_bank | input | 1 | Bank targeted by both write paths |
| wr_addr | input | 4 | Normal write register number |
| wr_data | input | 32 | Normal write value |
| link_we | input | 1 | Call-link write strobe (register 15) |
| link_data | input | 32 | Return address for the link register |
| rd_addr_a | input | 4 | Read port A register number |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register number |
| rd_data_b | output | 32 | Read port B data |

## Verification
The checker watches four behaviours on every cycle. It checks forwarding of a matching normal write to both ports and priority of the link path on register 15. It also checks the all-zero state after reset and that a stored value persists into the next cycle. Bank isolation, blocking of forwarding across banks, dual writes in one cycle and the ignored inputs involve history over many cycles. These are shown by the bench's reference model, which mirrors both banks and compares both ports after every stimulus in directed and random sequences.

// File: rtl/rf_pkg.sv
package rf_pkg;
   // Where a read port takes its value from in the current cycle.
   typedef enum logic [1:0] {
      SRC_STORE = 2'd0,
      SRC_MAIN  = 2'd1,
      SRC_LINK  = 2'd2
   } rd_src_e;

   localparam int unsigned DEF_DATA_W   = 32;
   localparam int unsigned DEF_NUM_REGS = 16;
   localparam int unsigned DEF_BANKS    = 2;
   localparam int unsigned DEF_LINK_IDX = 15;
endpackage

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned LINK_IDX = 15,
   localparam int unsigned AW = $clog2(NUM_REGS),
   localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              rst,
   input  logic              wr_en,
   input  logic [BW-1:0]     wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_we,
   input  logic [DATA_W-1:0] link_data,
   output logic              main_we,
   output logic [BW-1:0]     main_bank,
   output logic [AW-1:0]     main_addr,
   output logic [DATA_W-1:0] main_data,
   output logic              lnk_we,
   output logic [BW-1:0]     lnk_bank,
   output logic [AW-1:0]     lnk_addr,
   output logic [DATA_W-1:0] lnk_data
);
   localparam logic [AW-1:0] LINK_A = AW'(LINK_IDX);

   logic clash;

   always_comb begin
      clash     = link_we && (wr_addr == LINK_A);
      // The link path owns its register; a colliding normal write is dropped.
      main_we   = wr_en && !rst && !clash;
      main_bank = wr_bank;
      main_addr = wr_addr;
      main_data = wr_data;
      lnk_we    = link_we && !rst;
      lnk_bank  = wr_bank;
      lnk_addr  = LINK_A;
      lnk_data  = link_data;
   end
endmodule

// File: rtl/rf_bank_array.sv
module rf_bank_array #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned NUM_BANKS = 2,
   localparam int unsigned AW     = $clog2(NUM_REGS),
   localparam int unsigned BW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned FLAT_W = NUM_BANKS * NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_0,
   input  logic [BW-1:0]     bank_0,
   input  logic [AW-1:0]     addr_0,
   input  logic [DATA_W-1:0] data_0,
   input  logic              we_1,
   input  logic [BW-1:0]     bank_1,
   input  logic [AW-1:0]     addr_1,
   input  logic [DATA_W-1:0] data_1,
   output logic [FLAT_W-1:0] store_flat
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] words [NUM_REGS];
      logic hit0, hit1;

      assign hit0 = we_0 && (bank_0 == BW'(b));
      assign hit1 = we_1 && (bank_1 == BW'(b));

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) words[r] <= '0;
         end else begin
            if (hit0) words[addr_0] <= data_0;
            if (hit1) words[addr_1] <= data_1;
         end
      end

      for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
         assign store_flat[((b*NUM_REGS)+r)*DATA_W +: DATA_W] = words[r];
      end
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import rf_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned NUM_BANKS = 2,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned AW     = $clog2(NUM_REGS),
   localparam int unsigned BW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned FLAT_W = NUM_BANKS * NUM_REGS * DATA_W
) (
   input  logic [FLAT_W-1:0] store_flat,
   input  logic [BW-1:0]     rd_bank,
   input  logic [AW-1:0]     rd_addr,
   input  logic              fa_we,
   input  logic [BW-1:0]     fa_bank,
   input  logic [AW-1:0]     fa_addr,
   input  logic [DATA_W-1:0] fa_data,
   input  logic              fb_we,
   input  logic [BW-1:0]     fb_bank,
   input  logic [AW-1:0]     fb_addr,
   input  logic [DATA_W-1:0] fb_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] stored;
   rd_src_e           src;

   always_comb begin
      stored = '0;
      for (int i = 0; i < NUM_BANKS * NUM_REGS; i++) begin
         if (i == (int'(rd_bank) * NUM_REGS + int'(rd_addr)))
            stored = store_flat[i*DATA_W +: DATA_W];
      end
   end

   if (BYPASS_EN) begin : g_fwd
      always_comb begin
         if (fb_we && fb_bank == rd_bank && fb_addr == rd_addr)
            src = SRC_LINK;
         else if (fa_we && fa_bank == rd_bank && fa_addr == rd_addr)
            src = SRC_MAIN;
         else
            src = SRC_STORE;
      end
   end else begin : g_nofwd
      assign src = SRC_STORE;
   end

   always_comb begin
      unique case (src)
         SRC_MAIN: rd_data = fa_data;
         SRC_LINK: rd_data = fb_data;
         default:  rd_data = stored;
      endcase
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
   parameter int unsigned DATA_W    = rf_pkg::DEF_DATA_W,
   parameter int unsigned NUM_REGS  = rf_pkg::DEF_NUM_REGS,
   parameter int unsigned NUM_BANKS = rf_pkg::DEF_BANKS,
   parameter int unsigned LINK_IDX  = rf_pkg::DEF_LINK_IDX,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned AW     = $clog2(NUM_REGS),
   localparam int unsigned BW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned FLAT_W = NUM_BANKS * NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BW-1:0]     bank_sel,
   input  logic              wr_en,
   input  logic [BW-1:0]     wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_we,
   input  logic [DATA_W-1:0] link_data,
   input  logic [AW-1:0]     rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [AW-1:0]     rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);
   if (DATA_W < 1) begin : g_bad_width
      $error("banked_regfile: DATA_W must be positive");
   end
   if (NUM_REGS < 2 || (1 << AW) != NUM_REGS) begin : g_bad_depth
      $error("banked_regfile: NUM_REGS must be a power of two >= 2");
   end
   if (NUM_BANKS < 2 || (1 << BW) != NUM_BANKS) begin : g_bad_banks
      $error("banked_regfile: NUM_BANKS must be a power of two >= 2");
   end
   if (LINK_IDX >= NUM_REGS) begin : g_bad_link
      $error("banked_regfile: LINK_IDX out of range");
   end

   logic              m_we, l_we;
   logic [BW-1:0]     m_bank, l_bank;
   logic [AW-1:0]     m_addr, l_addr;
   logic [DATA_W-1:0] m_data, l_data;
   logic [FLAT_W-1:0] store_flat;

   rf_write_merge #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .LINK_IDX(LINK_IDX)
   ) u_merge (
      .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .link_we(link_we), .link_data(link_data),
      .main_we(m_we), .main_bank(m_bank), .main_addr(m_addr), .main_data(m_data),
      .lnk_we(l_we), .lnk_bank(l_bank), .lnk_addr(l_addr), .lnk_data(l_data)
   );

   rf_bank_array #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS)
   ) u_store (
      .clk(clk), .rst(rst),
      .we_0(m_we), .bank_0(m_bank), .addr_0(m_addr), .data_0(m_data),
      .we_1(l_we), .bank_1(l_bank), .addr_1(l_addr), .data_1(l_data),
      .store_flat(store_flat)
   );

   logic [AW-1:0]     rd_addr_v [2];
   logic [DATA_W-1:0] rd_data_v [2];

   assign rd_addr_v[0] = rd_addr_a;
   assign rd_addr_v[1] = rd_addr_b;
   assign rd_data_a    = rd_data_v[0];
   assign rd_data_b    = rd_data_v[1];

   for (genvar p = 0; p < 2; p++) begin : g_port
      rf_read_port #(
         .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .BYPASS_EN(BYPASS_EN)
      ) u_rd (
         .store_flat(store_flat), .rd_bank(bank_sel), .rd_addr(rd_addr_v[p]),
         .fa_we(m_we), .fa_bank(m_bank), .fa_addr(m_addr), .fa_data(m_data),
         .fb_we(l_we), .fb_bank(l_bank), .fb_addr(l_addr), .fb_data(l_data),
         .rd_data(rd_data_v[p])
      );
   end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned LINK_IDX = 15,
   localparam int unsigned AW = $clog2(NUM_REGS),
   localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic              clk,
   input logic              rst,
   input logic [BW-1:0]     bank_sel,
   input logic              wr_en,
   input logic [BW-1:0]     wr_bank,
   input logic [AW-1:0]     wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              link_we,
   input logic [DATA_W-1:0] link_data,
   input logic [AW-1:0]     rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [AW-1:0]     rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b
);
   localparam logic [AW-1:0] LNK = AW'(LINK_IDX);

   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !wr_en && !link_we) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1

   AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && wr_en && !link_we && wr_addr == rd_addr_a && wr_bank == bank_sel)
       && $stable(rd_addr_a) && $stable(bank_sel) && !wr_en && !link_we)
      |-> rd_data_a == $past(wr_data)); // R2

   AST_LINK_PRIORITY: assert property (@(posedge clk) disable iff (rst)
      (link_we && wr_bank == bank_sel && rd_addr_b == LNK) |-> rd_data_b == link_data); // R4

   AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_bank == bank_sel && rd_addr_a == wr_addr && !(link_we && wr_addr == LNK))
      |-> rd_data_a == wr_data); // R6

   AST_FWD_PORT_B: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_bank == bank_sel && rd_addr_b == wr_addr && !(link_we && wr_addr == LNK))
      |-> rd_data_b == wr_data); // R6
endmodule

bind banked_regfile rf_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .LINK_IDX(LINK_IDX)
) u_chk (
   .clk(clk), .rst(rst), .bank_sel(bank_sel), .wr_en(wr_en), .wr_bank(wr_bank),
   .wr_addr(wr_addr), .wr_data(wr_data), .link_we(link_we), .link_data(link_data),
   .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        bank_sel, wr_en, wr_bank, link_we;
   logic [3:0]  wr_addr, rd_addr_a, rd_addr_b;
   logic [31:0] wr_data, link_data, rd_data_a, rd_data_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] mdl [2][16];

   always #2 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst(rst), .bank_sel(bank_sel), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_addr(wr_addr), .wr_data(wr_data), .link_we(link_we), .link_data(link_data),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
   );

   function automatic logic [31:0] expect_rd(input logic [3:0] a);
      logic [31:0] v;
      v = mdl[bank_sel][a];
      if (!rst) begin
         if (link_we && wr_bank == bank_sel && a == 4'd15) v = link_data;
         else if (wr_en && wr_bank == bank_sel && a == wr_addr) v = wr_data;
      end
      return v;
   endfunction

   task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, optionally check both ports, then advance the model.
   task automatic step(input bit r, input bit bs, input bit we, input bit wb,
                       input logic [3:0] wa, input logic [31:0] wd,
                       input bit lw, input logic [31:0] ld,
                       input logic [3:0] ra, input logic [3:0] rb,
                       input bit chk, input string tag);
      @(negedge clk);
      rst = r; bank_sel = bs; wr_en = we; wr_bank = wb; wr_addr = wa; wr_data = wd;
      link_we = lw; link_data = ld; rd_addr_a = ra; rd_addr_b = rb;
      #1;
      if (chk) begin
         compare({tag, " port A"}, rd_data_a, expect_rd(ra));
         compare({tag, " port B"}, rd_data_b, expect_rd(rb));
      end
      @(posedge clk);
      if (r) begin
         for (int b = 0; b < 2; b++) for (int i = 0; i < 16; i++) mdl[b][i] = '0;
      end else begin
         if (we) mdl[wb][wa] = wd;
         if (lw) mdl[wb][15] = ld;
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; bank_sel = 0; wr_en = 0; wr_bank = 0; wr_addr = 0; wr_data = 0;
      link_we = 0; link_data = 0; rd_addr_a = 0; rd_addr_b = 0;
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      // R1: every register of both banks reads zero
      for (int i = 0; i < 16; i += 2) step(0, 0, 0, 0, 0, 0, 0, 0, 4'(i), 4'(i+1), 1, "R1 bank0");
      for (int i = 0; i < 16; i += 2) step(0, 1, 0, 0, 0, 0, 0, 0, 4'(i), 4'(i+1), 1, "R1 bank1");
      // R2 / R6: write, forward in same cycle, then stored
      step(0, 0, 1, 0, 4'd3, 32'hA5A5_0003, 0, 0, 4'd3, 4'd4, 1, "R6 fwd");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd3, 1, "R2 stored");
      // R3: two ports, two different registers
      step(0, 0, 1, 0, 4'd4, 32'h0000_0444, 0, 0, 4'd0, 4'd0, 1, "R2 write");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd4, 1, "R3 independent");
      // R9: register 0 ordinary
      step(0, 0, 1, 0, 4'd0, 32'h5555_0000, 0, 0, 4'd0, 4'd1, 1, "R9 fwd r0");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 4'd0, 1, "R9 stored r0");
      // R7 / R8: alternate bank write, no forward into bank0, bank0 untouched
      step(0, 0, 1, 1, 4'd3, 32'hBBBB_0003, 0, 0, 4'd3, 4'd3, 1, "R7 no cross fwd");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd0, 1, "R8 bank0 kept");
      step(0, 1, 0, 0, 0, 0, 0, 0, 4'd3, 4'd4, 1, "R8 bank1 own");
      // R4: link write alone, then collision with normal write on 15
      step(0, 0, 0, 0, 0, 0, 1, 32'h0000_1000, 4'd15, 4'd15, 1, "R4 link fwd");
      step(0, 0, 1, 0, 4'd15, 32'hDEAD_BEEF, 1, 32'h0000_2000, 4'd15, 4'd14, 1, "R4 link wins fwd");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd15, 4'd15, 1, "R4 link wins stored");
      // R5: link and normal write to another register in the same cycle
      step(0, 1, 1, 1, 4'd7, 32'h7777_7777, 1, 32'h0000_3000, 4'd7, 4'd15, 1, "R5 dual fwd");
      step(0, 1, 0, 0, 0, 0, 0, 0, 4'd7, 4'd15, 1, "R5 dual stored");
      // R10: strobes low, other inputs wiggle
      step(0, 0, 0, 0, 4'd3, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 4'd3, 4'd15, 1, "R10 idle");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd15, 1, "R10 unchanged");
      // R11: write during reset ignored, then everything zero
      step(1, 0, 1, 0, 4'd9, 32'h9999_9999, 1, 32'h1234_5678, 4'd9, 4'd15, 1, "R11 no fwd in rst");
      step(0, 0, 0, 0, 0, 0, 0, 0, 4'd9, 4'd15, 1, "R11 nothing stored");
      // R2 random traffic against the model
      for (int n = 0; n < 400; n++) begin
         step(0, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), $urandom,
              ($urandom % 4) == 0, $urandom, 4'($urandom), 4'($urandom), 1, "R2 random");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule